// File: doc/BRIEF.md
# Program Memory Table Read Unit

This unit fetches one wide word from program memory on request. A low pointer byte and a high pointer byte, both held in registers that can be written and read, together form the table address. A start strobe sends that address to a synchronous program ROM. Every fetch runs for exactly two clock cycles. In the first cycle the unit presents the address with the ROM enable high. In the second cycle the ROM data arrives. The low byte of that data goes out on a destination bus together with a one-cycle valid pulse. The upper bits are written into a holding register that can only be read.

A CPU register write cannot restore the holding register. Each new fetch replaces its contents. Software that fetches in both the main flow and an interrupt handler must save the holding register itself before another fetch can overwrite it.

Top module: `tbr_unit`

## Requirements
- R1: After asynchronous reset, both pointer bytes and the holding register are zero, and busy_o, rom_en_o and dst_valid_o are low.
- R2: A register write with reg_addr_i equal to LO_ADDR (default 8'h07) loads the low pointer byte, and one equal to HI_ADDR (default 8'h1F) loads the high pointer byte. Both bytes read back on reg_rdata_o from the following cycle.
- R3: A start_i sampled while idle makes the next cycle the address cycle. In that cycle rom_en_o=1, busy_o=1 and rom_addr_o={high byte, low byte} as the pointers stood before that edge.
- R4: The cycle after the address cycle is the data cycle. In it dst_valid_o=1 for exactly that one cycle, dst_data_o=rom_data_i[7:0], busy_o=1 and rom_en_o=0.
- R5: At the end of the data cycle the holding register takes rom_data_i[WORD_W-1:8]. It reads on reg_rdata_o at HOLD_ADDR (default 8'h08), zero-extended to 8 bits.
- R6: A register write to HOLD_ADDR leaves the holding register unchanged.
- R7: A start_i sampled while busy_o is high is ignored. It does not launch a fetch and does not lengthen the current one.
- R8: Every completed fetch overwrites the holding register, replacing any value an earlier fetch left there.
- R9: busy_o is high only in the address and data cycles, so each fetch keeps it high for exactly two cycles.
- R10: A pointer write during a fetch does not change the address of that fetch, but it does update the pointer for later fetches.
- R11: reg_rdata_o is zero for any register address other than LO_ADDR, HI_ADDR and HOLD_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address for read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| start_i | input | 1 | Fetch request strobe |
| rom_en_o | output | 1 | ROM read enable (address cycle) |
| rom_addr_o | output | 16 | ROM word address |
| rom_data_i | input | WORD_W | ROM read data, valid in the cycle after rom_en_o |
| dst_data_o | output | 8 | Low byte of the fetched word |
| dst_valid_o | output | 1 | Fetch done pulse, data cycle |
| busy_o | output | 1 | Fetch in progress |

## Verification
The assertions check on every cycle that a fetch moves from start to the address cycle, then to the data cycle, then to idle. They also check that a start while busy never produces an address cycle, that the ROM address equals the pointers of the cycle before, and that the holding register changes only at the end of a data cycle, and then only to the fetched upper bits. Some behaviours can be shown only by the bench's scenarios against its reference model: a write to the holding address really being lost, a later fetch replacing an earlier result, a pointer write during a fetch reaching the next fetch, and the readback values of unmapped addresses.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  localparam int BYTE_W = 8;
  localparam int TAB_AW = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } tbr_state_e;
endpackage

// File: rtl/tbr_ptr_regs.sv
module tbr_ptr_regs
  import tbr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LO_ADDR = 8'h07,
  parameter logic [BYTE_W-1:0] HI_ADDR = 8'h1F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] ptr_lo_o,
  output logic [BYTE_W-1:0] ptr_hi_o
);
  logic [BYTE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (we_i) begin
      if (addr_i == LO_ADDR) lo_q <= wdata_i;
      if (addr_i == HI_ADDR) hi_q <= wdata_i;
    end
  end

  assign ptr_lo_o = lo_q;
  assign ptr_hi_o = hi_q;
endmodule

// File: rtl/tbr_seq.sv
module tbr_seq
  import tbr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TAB_AW-1:0] ptr_i,
  output logic              rom_en_o,
  output logic [TAB_AW-1:0] rom_addr_o,
  output logic              cap_o,
  output logic              busy_o
);
  tbr_state_e        state_q;
  logic [TAB_AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ADDR;
          addr_q  <= ptr_i;  // freeze address: later pointer writes wait for next fetch
        end
        ST_ADDR: state_q <= ST_DATA;
        ST_DATA: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rom_en_o   = (state_q == ST_ADDR);
  assign cap_o      = (state_q == ST_DATA);
  assign busy_o     = (state_q != ST_IDLE);
  assign rom_addr_o = addr_q;
endmodule

// File: rtl/tbr_hold.sv
module tbr_hold
  import tbr_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int HOLD_W = WORD_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [HOLD_W-1:0] hold_o,
  output logic [BYTE_W-1:0] rd_o
);
  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (cap_i) hold_q <= data_i[WORD_W-1:BYTE_W];
  end

  generate
    if (HOLD_W < BYTE_W) begin : g_pad
      assign rd_o = {{(BYTE_W-HOLD_W){1'b0}}, hold_q};
    end else begin : g_full
      assign rd_o = hold_q;
    end
  endgenerate

  assign hold_o = hold_q;
endmodule

// File: rtl/tbr_unit.sv
module tbr_unit
  import tbr_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter logic [7:0] LO_ADDR   = 8'h07,
  parameter logic [7:0] HI_ADDR   = 8'h1F,
  parameter logic [7:0] HOLD_ADDR = 8'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              start_i,
  output logic              rom_en_o,
  output logic [15:0]       rom_addr_o,
  input  logic [WORD_W-1:0] rom_data_i,
  output logic [7:0]        dst_data_o,
  output logic              dst_valid_o,
  output logic              busy_o
);
  localparam int HOLD_W = WORD_W - BYTE_W;

  logic [BYTE_W-1:0] ptr_lo_w, ptr_hi_w, hold_rd_w;
  logic [HOLD_W-1:0] hold_w;
  logic              cap_w;

  tbr_ptr_regs #(.LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .ptr_lo_o (ptr_lo_w),
    .ptr_hi_o (ptr_hi_w)
  );

  tbr_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .ptr_i      ({ptr_hi_w, ptr_lo_w}),
    .rom_en_o   (rom_en_o),
    .rom_addr_o (rom_addr_o),
    .cap_o      (cap_w),
    .busy_o     (busy_o)
  );

  tbr_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap_w),
    .data_i (rom_data_i),
    .hold_o (hold_w),
    .rd_o   (hold_rd_w)
  );

  always_comb begin
    unique case (reg_addr_i)
      LO_ADDR:   reg_rdata_o = ptr_lo_w;
      HI_ADDR:   reg_rdata_o = ptr_hi_w;
      HOLD_ADDR: reg_rdata_o = hold_rd_w;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign dst_data_o  = rom_data_i[BYTE_W-1:0];
  assign dst_valid_o = cap_w;
endmodule

// File: rtl/tbr_unit_chk.sv
module tbr_unit_chk #(
  parameter int WORD_W = 16,
  localparam int HOLD_W = WORD_W - 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              rom_en_o,
  input logic [15:0]       rom_addr_o,
  input logic [WORD_W-1:0] rom_data_i,
  input logic              dst_valid_o,
  input logic [7:0]        ptr_lo,
  input logic [7:0]        ptr_hi,
  input logic [HOLD_W-1:0] hold_q
);
  a_r3_start_launches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (rom_en_o && busy_o));

  a_r3_addr_from_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (rom_addr_o == $past({ptr_hi, ptr_lo})));

  a_r4_data_follows_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en_o |=> (dst_valid_o && busy_o && !rom_en_o));

  a_r5_hold_takes_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_valid_o |=> (hold_q == $past(rom_data_i[WORD_W-1:8])));

  a_r6_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dst_valid_o |=> $stable(hold_q));

  a_r7_no_launch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> !rom_en_o);

  a_r9_idle_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_valid_o |=> !busy_o);

  a_r9_busy_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_en_o, dst_valid_o}) && (busy_o == (rom_en_o || dst_valid_o)));
endmodule

bind tbr_unit tbr_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .rom_en_o    (rom_en_o),
  .rom_addr_o  (rom_addr_o),
  .rom_data_i  (rom_data_i),
  .dst_valid_o (dst_valid_o),
  .ptr_lo      (ptr_lo_w),
  .ptr_hi      (ptr_hi_w),
  .hold_q      (hold_w)
);

// File: tb/sim_tbr_unit.sv
module sim_tbr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 16;
  localparam logic [7:0] LO_A = 8'h07, HI_A = 8'h1F, HO_A = 8'h08;

  logic clk = 0, rst_n = 0;
  logic we = 0, start = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata, dst;
  logic en, valid, busy;
  logic [15:0] raddr;
  logic [WORD_W-1:0] rom_q = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbr_unit #(.WORD_W(WORD_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .start_i(start),
    .rom_en_o(en), .rom_addr_o(raddr), .rom_data_i(rom_q),
    .dst_data_o(dst), .dst_valid_o(valid), .busy_o(busy)
  );

  function automatic logic [WORD_W-1:0] rom_f(input logic [15:0] a);
    logic [31:0] t;
    t = ({16'h0, a} * 32'd40503) ^ {19'h0, a[15:3]} ^ 32'h0000C3A5;
    return t[WORD_W-1:0];
  endfunction

  // synchronous ROM (environment)
  always @(posedge clk) if (en) rom_q <= rom_f(raddr);

  // reference model
  int ph = 0;
  logic [7:0] m_lo = 0, m_hi = 0, m_hold = 0;
  logic [15:0] m_addr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_lo = 0; m_hi = 0; m_hold = 0; m_addr = 0;
    end else begin
      if (ph == 2) m_hold = rom_q[WORD_W-1:8];
      if (ph == 0 && start) m_addr = {m_hi, m_lo};
      ph = (ph == 0) ? (start ? 1 : 0) : (ph == 1 ? 2 : 0);
      if (we && addr == LO_A) m_lo = wdata;
      if (we && addr == HI_A) m_hi = wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    logic [7:0] er;
    chk("R9 busy", busy, ph != 0);
    chk("R3 rom_en", en, ph == 1);
    chk("R4 valid", valid, ph == 2);
    if (ph == 1) chk("R3 rom_addr", raddr, m_addr);
    if (ph == 2) chk("R4 dst_data", dst, rom_q[7:0]);
    er = (addr == LO_A) ? m_lo : (addr == HI_A) ? m_hi : (addr == HO_A) ? m_hold : 8'h00;
    chk((addr == LO_A || addr == HI_A) ? "R2 rdata" : (addr == HO_A) ? "R5 rdata" : "R11 rdata",
        rdata, er);
  end

  task automatic drive(input logic w, input logic [7:0] a, input logic [7:0] d, input logic s);
    @(negedge clk); #1;
    we = w; addr = a; wdata = d; start = s;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 8'h00, 8'h00, 0);
  endtask

  // read a register and check it at the next negedge
  task automatic peek(input logic [7:0] a, input logic [7:0] exp, input string tag);
    drive(0, a, 8'h00, 0);
    @(negedge clk);
    chk(tag, rdata, exp);
  endtask

  logic [31:0] seed = 32'h1234_5678;
  int vcount;
  always @(posedge clk) if (rst_n && valid) vcount++;

  initial begin
    logic [15:0] a1, a2;
    vcount = 0;
    #(CLK_PERIOD*2 + 2);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 en", en, 0); chk("R1 valid", valid, 0);
    addr = LO_A; #1 chk("R1 ptr_lo", rdata, 0);
    addr = HO_A; #1 chk("R1 hold", rdata, 0);
    addr = 0;
    @(negedge clk); rst_n = 1;
    idle(2);

    // R2 pointer write/readback
    drive(1, LO_A, 8'h34, 0);
    drive(1, HI_A, 8'h12, 0);
    peek(LO_A, 8'h34, "R2 lo");
    peek(HI_A, 8'h12, "R2 hi");
    peek(8'h55, 8'h00, "R11 unmapped");

    // R3/R4/R5 single fetch
    drive(0, 0, 0, 1);
    idle(3);
    a1 = 16'h1234;
    peek(HO_A, rom_f(a1) >> 8, "R5 hold");

    // R6 write to holding address ignored
    drive(1, HO_A, 8'hA5, 0);
    peek(HO_A, rom_f(a1) >> 8, "R6 hold unchanged");

    // R7 start held high for 4 cycles: two fetches only
    vcount = 0;
    drive(0, 0, 0, 1); drive(0, 0, 0, 1); drive(0, 0, 0, 1); drive(0, 0, 0, 1);
    idle(4);
    chk("R7 fetch count", vcount, 2);

    // R10 pointer write during fetch, R8 overwrite
    drive(0, 0, 0, 1);
    drive(1, LO_A, 8'h99, 0);
    idle(3);
    peek(HO_A, rom_f(16'h1234) >> 8, "R10 old address used");
    drive(0, 0, 0, 1);
    idle(3);
    a2 = 16'h1299;
    peek(HO_A, rom_f(a2) >> 8, "R8 hold overwritten");

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ra;
      seed = seed * 32'd1103515245 + 32'd12345;
      case (seed[17:16])
        2'd0: ra = LO_A;
        2'd1: ra = HI_A;
        2'd2: ra = HO_A;
        default: ra = seed[31:24];
      endcase
      drive(seed[20], ra, seed[15:8], seed[22] | seed[23]);
    end
    idle(4);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule